// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Power-Up Sequencing

This block sits between a simple single-word host port and an asynchronous page-mode DRAM. It drives the row strobe, the column strobe, the write enable and the output enable, all active low. It also drives one address bus that carries the row first and then the column. Every strobe interval is a parameter counted in controller clock cycles. All strobes and the address bus come from flops, so they do not glitch.

After reset the block keeps all strobes inactive for a long pause. It then runs eight wake-up cycles. A parameter chooses the wake-up style: row-strobe-only cycles that step through rows 0 to 7, or column-before-row refresh cycles. A timer then requests a column-before-row refresh at a fixed interval. That refresh wins over a waiting host request but never cuts into a cycle that has already started.

The host holds `req_i` together with the direction, the address and the write data until `ready_o` pulses. A read returns its word on `rdata_o` in the same cycle as the pulse. Writes always use the early-write form, so the DRAM output never turns on during a write.

Top module: `dram_ctrl`

## Requirements
- R1: From reset release, `ras_n_o` and `cas_n_o` stay high for more than `PAUSE_CYCLES` clock cycles before any strobe goes low. In reset, all strobes are high and `ready_o` is low.
- R2: With `WAKE_CBR=0`, the first eight cycles after the pause are row-strobe-only cycles. In each one `ras_n_o` falls while `cas_n_o` is high, and `ma_o` carries row 0, 1, ... 7 in that order. No other cycle comes before the eighth.
- R3: With `WAKE_CBR=1`, the wake-up is eight column-before-row cycles, and no row-strobe-only cycle is ever issued.
- R4: Every refresh is column-before-row. `cas_n_o` falls at least `T_CSR` cycles before `ras_n_o` falls.
- R5: A write is an early write. `we_n_o` is low for at least `T_WCS` cycles before `cas_n_o` falls. `oe_n_o` stays high whenever `we_n_o` is low. `dq_oe_o` is high while the column strobe is low in a write.
- R6: In a host cycle, `ma_o` holds the row for at least `T_RAH` cycles from the fall of `ras_n_o`. `ma_o` then holds the column for at least ASC_LEN = max(`T_ASC`+1, `T_WCS`) cycles before `cas_n_o` falls. The +1 covers the two edge transitions.
- R7: A read captures `dq_i` CAP_LEN cycles after `cas_n_o` falls, where CAP_LEN = max(`T_CAC`, `T_AA`-ASC_LEN). This is the later of the two access limits, since the column is driven ASC_LEN cycles before the strobe. The captured word is the one last written to that address.
- R8: `ready_o` is a single-cycle pulse, one per completed host request. It never goes high before the wake-up has finished.
- R9: `ras_n_o` is high for at least `T_RP` cycles between any two consecutive cycles, wake-up cycles included.
- R10: A refresh becomes pending every `REFRESH_INTERVAL` clocks and is served before a waiting host request. Consecutive refreshes after wake-up are therefore no more than `REFRESH_INTERVAL` plus one host cycle and one precharge apart.
- R11: `addr_i` carries the row in its upper `MA_W` bits and the column in its lower `MA_W` bits. These appear on `ma_o` during the row and column phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2*MA_W | Row in the upper half, column in the lower half |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid with `ready_o` |
| ready_o | output | 1 | One-cycle completion pulse |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| oe_n_o | output | 1 | Output enable, active low |
| ma_o | output | MA_W | Multiplexed row/column address |
| dq_o | output | DW | Data to the DRAM |
| dq_oe_o | output | 1 | Drive enable for `dq_o` |
| dq_i | input | DW | Data from the DRAM |

## Verification
The bench includes a cycle-counting DRAM model. It returns a poison word until the column strobe has been low for the access time, so a capture one cycle early shows up as wrong data rather than passing. Random reads and writes use rows and columns drawn from disjoint ranges, so the row and column phases on `ma_o` can always be told apart. They run alongside directed cases: a read of a never-written word, back-to-back writes to one word, and requests issued during the pause, which must not complete before wake-up. A second instance with the other wake-up style shows whether the style parameter really changes the wake-up order. The long random run gives the refresh timer time to collide with host traffic, which exposes any gap that grows beyond the priority bound.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE, ST_IDLE, ST_CSR, ST_RAS, ST_RAH, ST_ASC, ST_CAS, ST_PRE
  } state_e;

  typedef enum logic [1:0] {OP_ROR, OP_CBR, OP_RD, OP_WR} op_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } strobe_t;

  localparam strobe_t STRB_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

  function automatic strobe_t strobe_decode(state_e st, op_e op);
    strobe_t s;
    s.ras_n = !(st inside {ST_RAS, ST_RAH, ST_ASC, ST_CAS});
    s.cas_n = !(st == ST_CSR || (st == ST_RAS && op == OP_CBR) || st == ST_CAS);
    s.we_n  = !(op == OP_WR && st inside {ST_ASC, ST_CAS});
    s.oe_n  = !(op == OP_RD && st == ST_CAS);
    s.dq_oe = !s.we_n;
    return s;
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CW = $clog2(INTERVAL);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
      pend_o <= (pend_o & ~ack_i) | wrap;
    end
  end

  // a pending refresh is only dropped when served
  assert_pend_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !ack_i |=> pend_o);
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int MA_W = 10
) (
  input  logic [MA_W-1:0] row_i,
  input  logic [MA_W-1:0] col_i,
  input  logic            col_sel_i,
  output logic [MA_W-1:0] ma_o
);
  assign ma_o = col_sel_i ? col_i : row_i;
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int MA_W             = 10,
  parameter int DW               = 16,
  parameter int PAUSE_CYCLES     = 20000,
  parameter int WAKE_CYCLES      = 8,
  parameter bit WAKE_CBR         = 1'b0,
  parameter int REFRESH_INTERVAL = 780,
  parameter int T_RP             = 6,
  parameter int T_RAS            = 5,
  parameter int T_CSR            = 1,
  parameter int T_RAH            = 1,
  parameter int T_ASC            = 1,
  parameter int T_WCS            = 1,
  parameter int T_CAS            = 2,
  parameter int T_CAC            = 2,
  parameter int T_AA             = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2*MA_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              ready_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [MA_W-1:0]   ma_o,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o,
  input  logic [DW-1:0]     dq_i
);
  localparam int ASC_LEN = (T_ASC + 1 > T_WCS) ? T_ASC + 1 : T_WCS;
  localparam int AA_LEFT = (T_AA > ASC_LEN) ? T_AA - ASC_LEN : 1;
  localparam int CAP_LEN = (T_CAC > AA_LEFT) ? T_CAC : AA_LEFT;
  localparam int CNT_W   = $clog2(PAUSE_CYCLES + T_RP + T_RAS + T_CSR + T_RAH
                                  + ASC_LEN + T_CAS + CAP_LEN + 1);
  localparam int WK_W    = $clog2(WAKE_CYCLES + 1);

  state_e              state_q, state_d;
  op_e                 op_q, op_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [WK_W-1:0]     wake_q, wake_d;
  logic [MA_W-1:0]     row_q, row_d, col_q, col_d, ma_d;
  logic [DW-1:0]       wdata_q, rdata_q;
  logic                ready_q, done, ref_pend, ref_ack;
  strobe_t             strb_q, strb_d;
  logic                col_sel_d;

  dram_refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_ref (
    .clk_i, .rst_ni, .ack_i(ref_ack), .pend_o(ref_pend)
  );

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : '0;
    wake_d  = wake_q;
    row_d   = row_q;
    col_d   = col_q;
    ref_ack = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ST_PAUSE: if (cnt_q == '0) state_d = ST_IDLE;
      ST_IDLE: begin
        if (wake_q != '0) begin
          wake_d = wake_q - 1'b1;
          if (WAKE_CBR) begin
            op_d = OP_CBR; state_d = ST_CSR; cnt_d = CNT_W'(T_CSR - 1);
          end else begin
            op_d    = OP_ROR; state_d = ST_RAS; cnt_d = CNT_W'(T_RAS - 1);
            row_d   = MA_W'(WAKE_CYCLES) - MA_W'(wake_q);
          end
        end else if (ref_pend) begin
          ref_ack = 1'b1;
          op_d = OP_CBR; state_d = ST_CSR; cnt_d = CNT_W'(T_CSR - 1);
        end else if (req_i) begin
          op_d    = we_i ? OP_WR : OP_RD;
          row_d   = addr_i[2*MA_W-1:MA_W];
          col_d   = addr_i[MA_W-1:0];
          state_d = ST_RAH; cnt_d = CNT_W'(T_RAH - 1);
        end
      end
      ST_CSR: if (cnt_q == '0) begin state_d = ST_RAS; cnt_d = CNT_W'(T_RAS - 1); end
      ST_RAS: if (cnt_q == '0) begin state_d = ST_PRE; cnt_d = CNT_W'(T_RP - 1); end
      ST_RAH: if (cnt_q == '0) begin state_d = ST_ASC; cnt_d = CNT_W'(ASC_LEN - 1); end
      ST_ASC: if (cnt_q == '0) begin
        state_d = ST_CAS;
        cnt_d   = (op_q == OP_WR) ? CNT_W'(T_CAS - 1) : CNT_W'(CAP_LEN - 1);
      end
      ST_CAS: if (cnt_q == '0) begin
        done = 1'b1; state_d = ST_PRE; cnt_d = CNT_W'(T_RP - 1);
      end
      ST_PRE: if (cnt_q == '0) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign strb_d    = strobe_decode(state_d, op_d);
  assign col_sel_d = state_d inside {ST_ASC, ST_CAS};

  dram_addr_mux #(.MA_W(MA_W)) u_mux (
    .row_i(row_d), .col_i(col_d), .col_sel_i(col_sel_d), .ma_o(ma_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      op_q    <= OP_ROR;
      cnt_q   <= CNT_W'(PAUSE_CYCLES - 1);
      wake_q  <= WK_W'(WAKE_CYCLES);
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
      strb_q  <= STRB_IDLE;
      ma_o    <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      wake_q  <= wake_d;
      row_q   <= row_d;
      col_q   <= col_d;
      strb_q  <= strb_d;
      ma_o    <= ma_d;
      ready_q <= done;
      if (state_q == ST_IDLE && state_d == ST_RAH) wdata_q <= wdata_i;
      if (done && op_q == OP_RD) rdata_q <= dq_i;
    end
  end

  assign ras_n_o = strb_q.ras_n;
  assign cas_n_o = strb_q.cas_n;
  assign we_n_o  = strb_q.we_n;
  assign oe_n_o  = strb_q.oe_n;
  assign dq_oe_o = strb_q.dq_oe;
  assign dq_o    = wdata_q;
  assign rdata_o = rdata_q;
  assign ready_o = ready_q;

  // precharge watch: ras high run length
  logic [7:0] hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= '0;
    else if (!ras_n_o) hi_cnt <= '0;
    else if (hi_cnt != 8'hff) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_strobes_high_pause_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_PAUSE |-> ras_n_o && cas_n_o);
  assert_cas_before_ras_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) && !cas_n_o |-> $past(!cas_n_o));
  assert_early_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) && !we_n_o |-> $past(!we_n_o) && oe_n_o);
  assert_no_oe_in_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> oe_n_o && dq_oe_o);
  assert_ready_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  assert_ready_after_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> wake_q == '0);
  assert_precharge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> hi_cnt >= 8'(T_RP));
endmodule

// File: tb/tb_dram_ctrl.sv
module tb_dram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MA_W = 10, DW = 16, PAUSE = 20000, WAKE = 8, REF_INT = 780;
  localparam int T_RP = 6, T_RAS = 5, T_CSR = 1, T_RAH = 1, T_ASC = 1;
  localparam int T_WCS = 1, T_CAS = 2, T_CAC = 2, T_AA = 3;
  localparam int ASC_LEN = (T_ASC + 1 > T_WCS) ? T_ASC + 1 : T_WCS;
  localparam int CAP_LEN = (T_CAC > T_AA - ASC_LEN) ? T_CAC : T_AA - ASC_LEN;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic req = 0, we = 0;
  logic [2*MA_W-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, dq_o, dq_i = 16'hDEAD;
  logic ready, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [MA_W-1:0] ma;
  logic [DW-1:0] rdata_b, dq_o_b;
  logic ready_b, ras_n_b, cas_n_b, we_n_b, oe_n_b, dq_oe_b;
  logic [MA_W-1:0] ma_b;

  dram_ctrl #(.MA_W(MA_W), .DW(DW), .PAUSE_CYCLES(PAUSE), .WAKE_CYCLES(WAKE),
    .WAKE_CBR(1'b0), .REFRESH_INTERVAL(REF_INT), .T_RP(T_RP), .T_RAS(T_RAS),
    .T_CSR(T_CSR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_WCS(T_WCS), .T_CAS(T_CAS),
    .T_CAC(T_CAC), .T_AA(T_AA)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .oe_n_o(oe_n), .ma_o(ma), .dq_o(dq_o),
    .dq_oe_o(dq_oe), .dq_i(dq_i));

  dram_ctrl #(.MA_W(MA_W), .DW(DW), .PAUSE_CYCLES(PAUSE), .WAKE_CYCLES(WAKE),
    .WAKE_CBR(1'b1), .REFRESH_INTERVAL(REF_INT), .T_RP(T_RP), .T_RAS(T_RAS),
    .T_CSR(T_CSR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_WCS(T_WCS), .T_CAS(T_CAS),
    .T_CAC(T_CAC), .T_AA(T_AA)) dut_cbr (
    .clk_i(clk), .rst_ni(rst_n), .req_i(1'b0), .we_i(1'b0), .addr_i('0),
    .wdata_i('0), .rdata_o(rdata_b), .ready_o(ready_b), .ras_n_o(ras_n_b),
    .cas_n_o(cas_n_b), .we_n_o(we_n_b), .oe_n_o(oe_n_b), .ma_o(ma_b),
    .dq_o(dq_o_b), .dq_oe_o(dq_oe_b), .dq_i(16'h0000));

  int n_tests = 0, n_fail = 0;
  task automatic check(bit ok, string req_tag, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_word(int i);
    return DW'(i * 945) ^ 16'h5A5A;
  endfunction

  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] ref_mem [0:255];
  initial for (int i = 0; i < 256; i++) begin mem[i] = init_word(i); ref_mem[i] = init_word(i); end

  // monitor and DRAM model for dut
  int cyc = 0, hi_run = 1000, lead_row = 0, col_run = 0, we_run = 0, acnt = 0;
  int wake_seen = 0, refs = 0, last_ref = -1, ops_done = 0;
  bit first_low = 0, prev_ras = 1, prev_cas = 1, prev_ready = 0, host_cyc = 0;
  logic [3:0] m_row = '0, m_col = '0;
  logic [MA_W-1:0] cur_row = '0, cur_col = '0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (!first_low && (!ras_n || !cas_n)) begin
      first_low = 1;
      check(cyc > PAUSE, "R1", "first strobe low cycle", cyc, PAUSE + 1);
    end
    if (prev_ras && !ras_n) begin
      check(hi_run >= T_RP, "R9", "ras precharge", hi_run, T_RP);
      if (!cas_n) begin
        check(!prev_cas, "R4", "cas before ras", prev_cas, 0);
        check(wake_seen == WAKE, "R2", "refresh before wake-up done", wake_seen, WAKE);
        if (last_ref >= 0)
          check(cyc - last_ref <= REF_INT + 20, "R10", "refresh gap", cyc - last_ref, REF_INT);
        last_ref = cyc; refs++;
        host_cyc = 0;
      end else if (wake_seen < WAKE) begin
        check(ma == MA_W'(wake_seen), "R2", "wake row", ma, wake_seen);
        wake_seen++;
        host_cyc = 0;
      end else begin
        check(ma == cur_row, "R11", "row on ma", ma, cur_row);
        host_cyc = 1; lead_row = 0; col_run = 0;
      end
      m_row = ma[3:0];
    end
    if (prev_cas && !cas_n && !ras_n && host_cyc) begin
      check(lead_row >= T_RAH, "R6", "row hold cycles", lead_row, T_RAH);
      check(col_run >= ASC_LEN, "R6", "column setup cycles", col_run, ASC_LEN);
      check(ma == cur_col, "R11", "column on ma", ma, cur_col);
      m_col = ma[3:0];
      if (!we_n) begin
        check(we_run >= T_WCS, "R5", "write setup cycles", we_run, T_WCS);
        check(oe_n && dq_oe, "R5", "oe high and dq driven", {oe_n, dq_oe}, 3);
        mem[{m_row, m_col}] = dq_o;
      end
    end
    if (!we_n && !oe_n) check(0, "R5", "oe low during write", 0, 1);
    if (ready) begin
      check(!prev_ready, "R8", "ready pulse width", 2, 1);
      check(wake_seen == WAKE, "R8", "ready before wake-up", wake_seen, WAKE);
    end
    // counter updates
    if (!ras_n && cas_n && host_cyc) begin
      if (ma == cur_row && col_run == 0) lead_row++;
      else if (ma == cur_col) col_run++;
    end
    we_run = we_n ? 0 : we_run + 1;
    hi_run = ras_n ? hi_run + 1 : 0;
    if (!ras_n && !cas_n && !oe_n && we_n) begin
      acnt++;
      dq_i = (acnt >= CAP_LEN) ? mem[{m_row, m_col}] : 16'hDEAD;
    end else begin
      acnt = 0; dq_i = 16'hDEAD;
    end
    prev_ras = ras_n; prev_cas = cas_n; prev_ready = ready;
  end

  // monitor for dut_cbr
  int cyc_b = 0, cbr_b = 0, ror_b = 0;
  bit first_low_b = 0, prev_ras_b = 1, prev_cas_b = 1;
  always @(negedge clk) if (rst_n) begin
    cyc_b++;
    if (!first_low_b && (!ras_n_b || !cas_n_b)) begin
      first_low_b = 1;
      check(cyc_b > PAUSE, "R1", "first strobe low (cbr wake)", cyc_b, PAUSE + 1);
    end
    if (prev_ras_b && !ras_n_b) begin
      if (cas_n_b) ror_b++;
      else begin
        cbr_b++;
        check(!prev_cas_b, "R4", "cas before ras (cbr wake)", prev_cas_b, 0);
      end
    end
    prev_ras_b = ras_n_b; prev_cas_b = cas_n_b;
  end

  task automatic host_op(bit wr, int row, int col, logic [DW-1:0] d);
    int t;
    @(negedge clk);
    cur_row = MA_W'(row); cur_col = MA_W'(col);
    addr = {MA_W'(row), MA_W'(col)}; we = wr; wdata = d; req = 1;
    t = 0;
    do begin @(negedge clk); t++; end while (!ready && t < 30000);
    req = 0;
    check(ready, wr ? "R8" : "R7", "request completion", ready, 1);
    if (ready) begin
      ops_done++;
      if (wr) ref_mem[{4'(row), 4'(col)}] = d;
      else check(rdata == ref_mem[{4'(row), 4'(col)}], "R7", "read data",
                 rdata, ref_mem[{4'(row), 4'(col)}]);
    end
  endtask

  bit finished = 0;
  initial begin
    int seed, r, c;
    seed = 32'h1f2e3d;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n && !ready, "R1", "reset state",
          {ras_n, cas_n, we_n, oe_n, ready}, 5'b11110);
    check(!ready, "R8", "ready low in reset", ready, 0);
    rst_n = 1;
    // issued during the pause: must wait for wake-up
    host_op(1, 3, 21, 16'hA5C3);
    host_op(0, 3, 21, 16'h0);
    host_op(0, 7, 30, 16'h0);              // never written: initial pattern
    host_op(1, 5, 17, 16'h1111);           // back-to-back writes same word
    host_op(1, 5, 17, 16'h2222);
    host_op(0, 5, 17, 16'h0);
    host_op(1, 0, 16, 16'hFFFF);           // lowest row/column pair
    host_op(0, 0, 16, 16'h0);
    for (int i = 0; i < 300; i++) begin
      r = $urandom % 16; c = 16 + $urandom % 16;
      host_op(1'($urandom % 2), r, c, DW'($urandom));
      if ($urandom % 4 == 0) repeat ($urandom % 40) @(negedge clk);
    end
    check(wake_seen == WAKE, "R2", "wake-up cycle count", wake_seen, WAKE);
    check(refs >= 2, "R10", "refresh count", refs, 2);
    check(ops_done == 308, "R8", "completed requests", ops_done, 308);
    check(cbr_b >= WAKE && ror_b == 0, "R3", "cbr wake-up style", cbr_b * 100 + ror_b, WAKE * 100);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule